// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block turns a virtual address into a real page number by searching a hashed page table. The table sits in an internal memory with synchronous reads. It is organised as groups of eight two-word entries. The first word of an entry carries the tag and the valid bit. The second word carries the real page number, the protection bits and the usage flags. A write port loads the table one entry at a time.

A request carries three things: a 64-bit virtual address, a segment-size select (256 MB or 1 TB) and a page shift. A table mask is sampled along with the request. The block hashes the address to pick a group. It reads that group's entries one per cycle and compares each tag against the tag it expects. If the primary group holds no match, it searches a secondary group, which is picked by the complemented hash. The first match ends the search. The search returns hit or miss, the real page number, the protection and no-execute bits, the referenced and changed flags, and whether the match came from the secondary pass. The response is held until it is taken.

Top module: `hpt_search`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0.
- R2: For a 256 MB segment (`req_seg1t`=0), the hash is (va >> 28) XOR (va[27:0] >> pshift), kept to 39 bits.
- R3: For a 1 TB segment (`req_seg1t`=1), let v = va >> 40. The hash is v XOR (v << 25) XOR (va[39:0] >> pshift), kept to 39 bits.
- R4: The expected tag holds va[63:23] in bits 47:7 and the segment size in bits 63:62 (00 for 256 MB, 01 for 1 TB). A match compares tag bits 63:7 only. Bits 6:0 of the stored tag are ignored.
- R5: An entry whose tag bit 0 (valid) is clear never matches.
- R6: The primary group's slots are searched first, from slot 0 up to slot 7, and the lowest matching slot wins. A hit in primary slot s raises `rsp_valid` 2+s cycles after the accepting edge.
- R7: The secondary pass runs only when all primary slots miss. It searches group (~hash & mask) and also requires tag bit 1 to be set. A hit in secondary slot s raises `rsp_valid` 10+s cycles after the accepting edge, with `rsp_second`=1.
- R8: A request that misses in both passes raises `rsp_valid` 17 cycles after the accepting edge, with `rsp_hit`=0 and every result field 0.
- R9: On a hit, `rsp_rpn` is data word bits 61:12, `rsp_pp` is bits 1:0, `rsp_nx` is bit 2, `rsp_chg` is bit 7 and `rsp_ref` is bit 8.
- R10: `req_ready` is 0 from the accepting edge until the response is taken. Requests presented during that time are ignored.
- R11: The response stays stable while `rsp_ready` is 0. After it is taken, `rsp_valid` drops and `req_ready` returns to 1 on the next cycle.
- R12: The group index is the low hash bits ANDed with `hash_mask`, sampled when the request is accepted. Table address = group * 8 + slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_va | input | 64 | Virtual address |
| req_seg1t | input | 1 | 1 selects a 1 TB segment, 0 selects 256 MB |
| req_pshift | input | 6 | Page shift in bits |
| hash_mask | input | GRP_AW | Group index mask |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | GRP_AW+SLOT_AW | Table entry address |
| tbl_tag | input | 64 | Tag word to write |
| tbl_data | input | 64 | Data word to write |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_second | output | 1 | The match came from the secondary pass |
| rsp_rpn | output | 50 | Real page number |
| rsp_pp | output | 2 | Page protection |
| rsp_nx | output | 1 | No-execute |
| rsp_ref | output | 1 | Referenced flag |
| rsp_chg | output | 1 | Changed flag |

## Verification
A wrong hash or mask sends the reads to the wrong group. The port then shows a miss, or a page number from a planted decoy entry, on the very response that should have hit. A read counter that is off by one, or a pass bit that is wrong, shows up as `rsp_valid` rising a cycle early or late. It can also show as `rsp_second` set on the wrong pass, so the bench checks the exact rising cycle against 2+slot. A result register or state machine that fails to hold shows as fields changing during a stalled `rsp_ready`, or as `req_ready` rising early, within one cycle of the fault.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   localparam int HPT_WORD_W = 64;
   localparam int HPT_HASH_W = 39;
   localparam int HPT_RPN_W  = 50;

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} hpt_state_e;

   typedef struct packed {
      logic [HPT_WORD_W-1:0] tag;
      logic [HPT_WORD_W-1:0] dat;
   } hpt_entry_t;

   typedef struct packed {
      logic                 hit;
      logic                 second;
      logic [HPT_RPN_W-1:0] rpn;
      logic [1:0]           pp;
      logic                 nx;
      logic                 refd;
      logic                 chg;
   } hpt_result_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
   import hpt_pkg::*;
#(
   parameter bit SUPPORT_1T = 1'b1
) (
   input  logic [63:0]           va,
   input  logic                  seg1t,
   input  logic [5:0]            pshift,
   output logic [HPT_HASH_W-1:0] hash
);
   logic [HPT_HASH_W-1:0] h_small;

   // 256 MB segment: segment id bits folded with page index bits
   assign h_small = HPT_HASH_W'(va[63:28]) ^ HPT_HASH_W'(va[27:0] >> pshift);

   generate
      if (SUPPORT_1T) begin : g_big
         logic [23:0]           vsid;
         logic [HPT_HASH_W-1:0] h_big;
         assign vsid  = va[63:40];
         assign h_big = HPT_HASH_W'(vsid) ^ HPT_HASH_W'({vsid, 25'b0})
                      ^ HPT_HASH_W'(va[39:0] >> pshift);
         assign hash  = seg1t ? h_big : h_small;
      end else begin : g_small_only
         logic unused_seg;
         assign unused_seg = seg1t;
         assign hash       = h_small;
      end
   endgenerate
endmodule

// File: rtl/hpt_table.sv
module hpt_table
   import hpt_pkg::*;
#(
   parameter int GRP_AW  = 6,
   parameter int SLOT_AW = 3
) (
   input  logic                        clk,
   input  logic                        we,
   input  logic [GRP_AW+SLOT_AW-1:0]   waddr,
   input  hpt_entry_t                  wentry,
   input  logic                        re,
   input  logic [GRP_AW+SLOT_AW-1:0]   raddr,
   output hpt_entry_t                  rentry
);
   localparam int DEPTH = 1 << (GRP_AW + SLOT_AW);

   hpt_entry_t mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wentry;
      if (re) rentry <= mem[raddr];
   end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
   import hpt_pkg::*;
(
   input  hpt_entry_t  ent,
   input  logic [56:0] exp_hi,
   input  logic        need_sec,
   output logic        hit,
   output hpt_result_t res
);
   logic unused_bits;
   assign unused_bits = ^{ent.tag[6:2], ent.dat[63:62], ent.dat[11:9], ent.dat[6:3]};

   // bits 6:0 of the tag carry flags and take no part in the compare
   assign hit = ent.tag[0] && (ent.tag[63:7] == exp_hi) && (!need_sec || ent.tag[1]);

   always_comb begin
      res.hit    = hit;
      res.second = need_sec;
      res.rpn    = ent.dat[61:12];
      res.pp     = ent.dat[1:0];
      res.nx     = ent.dat[2];
      res.refd   = ent.dat[8];
      res.chg    = ent.dat[7];
   end
endmodule

// File: rtl/hpt_search.sv
module hpt_search
   import hpt_pkg::*;
#(
   parameter int GRP_AW     = 6,
   parameter int SLOT_AW    = 3,
   parameter bit SUPPORT_1T = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic [63:0]               req_va,
   input  logic                      req_seg1t,
   input  logic [5:0]                req_pshift,
   input  logic [GRP_AW-1:0]         hash_mask,
   input  logic                      tbl_we,
   input  logic [GRP_AW+SLOT_AW-1:0] tbl_addr,
   input  logic [63:0]               tbl_tag,
   input  logic [63:0]               tbl_data,
   output logic                      rsp_valid,
   input  logic                      rsp_ready,
   output logic                      rsp_hit,
   output logic                      rsp_second,
   output logic [49:0]               rsp_rpn,
   output logic [1:0]                rsp_pp,
   output logic                      rsp_nx,
   output logic                      rsp_ref,
   output logic                      rsp_chg
);
   localparam int SLOTS = 1 << SLOT_AW;
   localparam int READS = 2 * SLOTS;
   localparam int CNT_W = SLOT_AW + 2;
   localparam int AW    = GRP_AW + SLOT_AW;

   generate
      if (GRP_AW < 1 || GRP_AW > 12) begin : g_bad_grp
         $error("hpt_search: GRP_AW out of range");
      end
      if (SLOT_AW < 1 || SLOT_AW > 4) begin : g_bad_slot
         $error("hpt_search: SLOT_AW out of range");
      end
   endgenerate

   hpt_state_e        state_q;
   logic [63:0]       va_q;
   logic              seg_q;
   logic [5:0]        sh_q;
   logic [GRP_AW-1:0] mask_q;
   logic [CNT_W-1:0]  rd_cnt_q;
   logic              cmp_vld_q;
   logic [SLOT_AW:0]  cmp_idx_q;
   hpt_result_t       res_q;

   logic [HPT_HASH_W-1:0] hash;
   logic [GRP_AW-1:0]     grp_pri, grp_sec;
   logic                  issuing;
   logic [AW-1:0]         raddr;
   hpt_entry_t            rentry, wentry;
   logic [56:0]           exp_hi;
   logic                  m_hit;
   hpt_result_t           m_res;
   logic                  unused_hash;

   hpt_hash #(.SUPPORT_1T(SUPPORT_1T)) u_hash (
      .va(va_q), .seg1t(seg_q), .pshift(sh_q), .hash(hash));

   assign unused_hash = ^hash[HPT_HASH_W-1:GRP_AW];
   assign grp_pri     = hash[GRP_AW-1:0] & mask_q;
   assign grp_sec     = ~hash[GRP_AW-1:0] & mask_q;
   assign issuing     = (state_q == ST_RUN) && (rd_cnt_q < CNT_W'(READS));
   assign raddr       = {rd_cnt_q[SLOT_AW] ? grp_sec : grp_pri, rd_cnt_q[SLOT_AW-1:0]};
   assign wentry      = '{tag: tbl_tag, dat: tbl_data};
   assign exp_hi      = {1'b0, seg_q, 14'b0, va_q[63:23]};

   hpt_table #(.GRP_AW(GRP_AW), .SLOT_AW(SLOT_AW)) u_table (
      .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wentry(wentry),
      .re(issuing), .raddr(raddr), .rentry(rentry));

   hpt_match u_match (
      .ent(rentry), .exp_hi(exp_hi), .need_sec(cmp_idx_q[SLOT_AW]),
      .hit(m_hit), .res(m_res));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         va_q      <= '0;
         seg_q     <= 1'b0;
         sh_q      <= '0;
         mask_q    <= '0;
         rd_cnt_q  <= '0;
         cmp_vld_q <= 1'b0;
         cmp_idx_q <= '0;
         res_q     <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               va_q      <= req_va;
               seg_q     <= req_seg1t;
               sh_q      <= req_pshift;
               mask_q    <= hash_mask;
               rd_cnt_q  <= '0;
               cmp_vld_q <= 1'b0;
               res_q     <= '0;
               state_q   <= ST_RUN;
            end
            ST_RUN: begin
               if (cmp_vld_q && m_hit) begin
                  res_q     <= m_res;
                  cmp_vld_q <= 1'b0;
                  state_q   <= ST_DONE;
               end else if (cmp_vld_q && cmp_idx_q == (SLOT_AW+1)'(READS-1)) begin
                  res_q     <= '0;
                  cmp_vld_q <= 1'b0;
                  state_q   <= ST_DONE;
               end else begin
                  cmp_vld_q <= issuing;
                  cmp_idx_q <= rd_cnt_q[SLOT_AW:0];
                  if (issuing) rd_cnt_q <= rd_cnt_q + 1'b1;
               end
            end
            ST_DONE: if (rsp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign rsp_valid  = (state_q == ST_DONE);
   assign rsp_hit    = res_q.hit;
   assign rsp_second = res_q.second;
   assign rsp_rpn    = res_q.rpn;
   assign rsp_pp     = res_q.pp;
   assign rsp_nx     = res_q.nx;
   assign rsp_ref    = res_q.refd;
   assign rsp_chg    = res_q.chg;
endmodule

// File: rtl/hpt_search_chk.sv
module hpt_search_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic        rsp_hit,
   input logic        rsp_second,
   input logic [49:0] rsp_rpn,
   input logic [1:0]  rsp_pp,
   input logic        rsp_nx,
   input logic        rsp_ref,
   input logic        rsp_chg
);
   logic [4:0] busy_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_cnt <= '0;
      else if (req_valid && req_ready) busy_cnt <= 5'd1;
      else if (!req_ready && !rsp_valid && busy_cnt != 5'd31) busy_cnt <= busy_cnt + 1'b1;
   end

   p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_second)
         && $stable(rsp_rpn) && $stable(rsp_pp) && $stable({rsp_nx, rsp_ref, rsp_chg})));

   p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> (!rsp_valid && req_ready));

   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_rpn == '0 && rsp_pp == '0 && !rsp_second
         && !rsp_nx && !rsp_ref && !rsp_chg));

   p_second_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_second) |-> rsp_hit);

   // R6 and R8: the response lands between 2 and 17 cycles after acceptance
   p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_valid) |-> (busy_cnt >= 5'd3 && busy_cnt <= 5'd18));

   p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !rsp_valid) |-> busy_cnt <= 5'd17);
endmodule

bind hpt_search hpt_search_chk u_chk (.*);

// File: tb/hpt_search_bench.sv
module hpt_search_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NENT = 512;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_va = '0;
   logic        req_seg1t = 1'b0;
   logic [5:0]  req_pshift = 6'd12;
   logic [5:0]  hash_mask = 6'h3F;
   logic        tbl_we = 1'b0;
   logic [8:0]  tbl_addr = '0;
   logic [63:0] tbl_tag = '0;
   logic [63:0] tbl_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic        rsp_hit, rsp_second, rsp_nx, rsp_ref, rsp_chg;
   logic [49:0] rsp_rpn;
   logic [1:0]  rsp_pp;

   logic [63:0] m_tag [NENT];
   logic [63:0] m_dat [NENT];

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpt_search u_hpt_search (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_va(req_va), .req_seg1t(req_seg1t), .req_pshift(req_pshift),
      .hash_mask(hash_mask), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
      .tbl_tag(tbl_tag), .tbl_data(tbl_data), .rsp_valid(rsp_valid),
      .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_second(rsp_second),
      .rsp_rpn(rsp_rpn), .rsp_pp(rsp_pp), .rsp_nx(rsp_nx),
      .rsp_ref(rsp_ref), .rsp_chg(rsp_chg));

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [38:0] ref_hash(input logic [63:0] va, input bit s1t, input int sh);
      logic [63:0] h, v;
      if (!s1t) h = (va >> 28) ^ ((va & 64'h0FFF_FFFF) >> sh);
      else begin
         v = va >> 40;
         h = v ^ (v << 25) ^ ((va & 64'hFF_FFFF_FFFF) >> sh);
      end
      return h[38:0];
   endfunction

   function automatic logic [63:0] ref_tag(input logic [63:0] va, input bit s1t);
      return ((va >> 23) << 7) | (s1t ? 64'h4000_0000_0000_0000 : 64'h0);
   endfunction

   function automatic int ref_index(input logic [63:0] va, input bit s1t, input int sh,
                                    input logic [5:0] msk, input bit sec, input int slot);
      logic [5:0] g;
      logic [38:0] h;
      h = ref_hash(va, s1t, sh);
      g = sec ? (~h[5:0] & msk) : (h[5:0] & msk);
      return int'(g) * 8 + slot;
   endfunction

   // expected result: latency, hit, secondary flag and data word
   task automatic ref_search(input logic [63:0] va, input bit s1t, input int sh, input logic [5:0] msk,
                             output int lat, output bit hit, output bit sec, output logic [63:0] d);
      logic [63:0] et, t;
      int idx;
      et = ref_tag(va, s1t);
      lat = 17; hit = 0; sec = 0; d = '0;
      for (int p = 0; p < 2; p++) begin
         for (int s = 0; s < 8; s++) begin
            idx = ref_index(va, s1t, sh, msk, p != 0, s);
            t = m_tag[idx];
            if (!hit && t[0] && (t[63:7] == et[63:7]) && (p == 0 || t[1])) begin
               hit = 1; sec = (p != 0); d = m_dat[idx]; lat = 2 + p * 8 + s;
            end
         end
      end
   endtask

   task automatic wr(input int idx, input logic [63:0] t, input logic [63:0] d);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 9'(idx); tbl_tag = t; tbl_data = d;
      m_tag[idx] = t; m_dat[idx] = d;
      @(posedge clk);
      #1 tbl_we = 1'b0;
   endtask

   task automatic clear_table();
      for (int i = 0; i < NENT; i++) wr(i, 64'h0, 64'h0);
   endtask

   task automatic plant(input logic [63:0] va, input bit s1t, input int sh, input logic [5:0] msk,
                        input bit sec, input int slot, input logic [6:0] low, input logic [63:0] xr,
                        input logic [63:0] d);
      wr(ref_index(va, s1t, sh, msk, sec, slot), (ref_tag(va, s1t) | 64'(low)) ^ xr, d);
   endtask

   task automatic run_search(input logic [63:0] va, input bit s1t, input int sh, input logic [5:0] msk,
                             input int hold, input string req);
      int lat;
      bit hit, sec;
      logic [63:0] d;
      logic [56:0] exp_f, act_f;
      ref_search(va, s1t, sh, msk, lat, hit, sec, d);
      exp_f = hit ? {1'b1, sec, d[61:12], d[1:0], d[2], d[8], d[7]} : '0;
      @(negedge clk);
      check(req_ready === 1'b1, "R10 idle ready", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_va = va; req_seg1t = s1t; req_pshift = 6'(sh); hash_mask = msk;
      @(posedge clk);
      @(negedge clk);
      // R10: a second request while busy must be ignored
      req_va = ~va; req_seg1t = ~s1t; req_pshift = 6'd20; hash_mask = 6'h01;
      for (int k = 1; k <= lat + hold; k++) begin
         @(posedge clk);
         @(negedge clk);
         check(rsp_valid === (k >= lat), {req, " R6 R7 R8 valid timing"}, 64'(rsp_valid), 64'(k >= lat));
         check(req_ready === 1'b0, "R10 busy", 64'(req_ready), 64'd0);
         if (k >= lat) begin
            act_f = {rsp_hit, rsp_second, rsp_rpn, rsp_pp, rsp_nx, rsp_ref, rsp_chg};
            check(act_f === exp_f, {req, " R9 R11 result"}, 64'(act_f), 64'(exp_f));
         end
         if (k == lat + hold) begin
            rsp_ready = 1'b1; req_valid = 1'b0;
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid === 1'b0 && req_ready === 1'b1, "R11 release",
            64'({rsp_valid, req_ready}), 64'b01);
      rsp_ready = 1'b0;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [63:0] va;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset", 64'({req_ready, rsp_valid}), 64'b10);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 after reset", 64'({req_ready, rsp_valid}), 64'b10);

      // R2 R4 R9: 256 MB hit at slot 3, flag bits in low tag, decoy differing at bit 7
      va = 64'h0000_0ABC_1234_5678;
      clear_table();
      plant(va, 0, 12, 6'h3F, 0, 0, 7'h01, 64'h80, 64'h0000_0000_0000_1185);
      plant(va, 0, 12, 6'h3F, 0, 3, 7'h7D, 64'h0, 64'h3ABC_DEF0_1234_5186);
      run_search(va, 0, 12, 6'h3F, 3, "R2 R4");

      // R5 R6: invalid match at slot 0, two valid matches at 2 and 6
      va = 64'h0000_0012_8765_4321;
      clear_table();
      plant(va, 0, 16, 6'h3F, 0, 0, 7'h00, 64'h0, 64'h1111_0000);
      plant(va, 0, 16, 6'h3F, 0, 2, 7'h11, 64'h0, 64'h2222_0083);
      plant(va, 0, 16, 6'h3F, 0, 6, 7'h01, 64'h0, 64'h3333_0102);
      run_search(va, 0, 16, 6'h3F, 0, "R5 R6");

      // R7: secondary slot 1 lacks bit 1, slot 4 has it
      va = 64'h0000_7654_3210_FEDC;
      clear_table();
      plant(va, 0, 12, 6'h3F, 1, 1, 7'h01, 64'h0, 64'h4444_0001);
      plant(va, 0, 12, 6'h3F, 1, 4, 7'h03, 64'h0, 64'h0FED_C000_5555_5087);
      run_search(va, 0, 12, 6'h3F, 1, "R7");

      // R8: no entry anywhere
      clear_table();
      run_search(64'h0000_0001_0000_0000, 0, 12, 6'h3F, 2, "R8");

      // R3 R4: 1 TB segment, decoy with 256 MB size bits at slot 1
      va = 64'h0000_1234_5678_9ABC;
      clear_table();
      plant(va, 1, 16, 6'h3F, 0, 1, 7'h01, 64'h4000_0000_0000_0000, 64'h6666_0000);
      plant(va, 1, 16, 6'h3F, 0, 3, 7'h05, 64'h0, 64'h2000_0000_7777_7103);
      run_search(va, 1, 16, 6'h3F, 0, "R3 R4");

      // R12: narrowed mask, decoy in the unmasked group
      va = 64'h0000_0F0F_ABCD_0123;
      clear_table();
      plant(va, 0, 12, 6'h3F, 0, 0, 7'h01, 64'h0, 64'h8888_0000);
      plant(va, 0, 12, 6'h0F, 0, 6, 7'h01, 64'h0, 64'h9999_9182);
      run_search(va, 0, 12, 6'h0F, 0, "R12");

      // mixed patterns
      for (int i = 0; i < 8; i++) begin
         int slot;
         bit s1t;
         int sh;
         va = {16'h0, $urandom(), 16'($urandom())};
         s1t = 1'($urandom_range(0, 1));
         sh = 12 + 4 * $urandom_range(0, 3);
         slot = $urandom_range(0, 15);
         clear_table();
         plant(va, s1t, sh, 6'h3F, slot >= 8, slot % 8,
               7'(($urandom() & 32'h7C) | (slot >= 8 ? 3 : 1)), 64'h0,
               {2'b0, 30'($urandom()), 20'($urandom()), 12'($urandom())});
         run_search(va, s1t, sh, 6'h3F, i % 3, "R2 R3 R6 R7 mix");
      end

      summary();
   end
endmodule